// File: doc/BRIEF.md
# Interrupt Priority and Threshold Register File

This block holds the priority state of a platform-level interrupt controller. Each interrupt source numbered 1 to `NUM_SRC` has one priority register, and each target context has one threshold register. Source 0 has no register. A simple single-cycle register bus reads and writes these registers. Each context gets one registered interrupt request output. A context's request is high when at least one source is pending, is enabled for that context, and has a priority strictly above that context's threshold.

Every write to a priority or threshold register is made legal before it is stored. The elaboration-time parameter `MAX_PRIO` selects the rule. If `MAX_PRIO + 1` is a power of two, the block keeps only the supported low bits of the written word, so any written value becomes a legal one. Otherwise the whole word is compared with `MAX_PRIO`, and a value above it is dropped, leaving the register unchanged. The pending vector and the per-context enable vectors come from neighbouring logic as plain inputs. Bit `s-1` of `src_pending` is source `s`. Bit `c*NUM_SRC + s-1` of `ctx_enable` enables source `s` for context `c`.

Top module: `intc_prio_regs`

## Requirements
- R1: The priority of source s (1..NUM_SRC) is at byte address PRIO_BASE + 4*(s-1). A read with bus_valid=1 and bus_write=0 returns the stored value, zero-extended, on bus_rdata in the cycle after the request.
- R2: The threshold of context c (0..NUM_CTX-1) is at byte address CTX_BASE + c*CTX_STRIDE, where CTX_STRIDE is a power of two. It is read back in the same way as R1.
- R3: When MAX_PRIO+1 is a power of two, a priority write stores bus_wdata modulo MAX_PRIO+1, which is its low $clog2(MAX_PRIO+1) bits.
- R4: When MAX_PRIO+1 is not a power of two, a priority write whose full 32-bit bus_wdata is at most MAX_PRIO is stored. A larger value is dropped, and the register keeps its previous contents.
- R5: Threshold writes follow the same legalization rule as priority writes, chosen by the same power-of-two test.
- R6: ctx_irq[c] is a register. It is 1 in the cycle after the stored state and inputs show some source s with src_pending[s-1]=1, ctx_enable[c*NUM_SRC+s-1]=1 and priority(s) > threshold(c). Otherwise it is 0 in that cycle. An accepted register write therefore shows on ctx_irq two clock edges after the write request is sampled.
- R7: A source whose priority is 0 never raises any context's request, even when it is pending and enabled with threshold 0.
- R8: An address that maps to no register reads as zero, and a write to it changes no register. This covers addresses past the last source, misaligned addresses, and non-zero offsets inside a context block.
- R9: Reset (synchronous, active high) clears every priority register, every threshold register, bus_rdata and ctx_irq.
- R10: bus_rdata is zero in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after a read request |
| src_pending | input | NUM_SRC | Pending flag per source, bit s-1 is source s |
| ctx_enable | input | NUM_CTX*NUM_SRC | Per-context enable vectors, NUM_SRC bits per context |
| ctx_irq | output | NUM_CTX | Registered interrupt request per context |

## Verification
The assertions assume that reset is held from time zero until the first clock edges, so every register has a known value before any history is looked at. They also assume that `src_pending` and `ctx_enable` change only between clock edges. The bench keeps to this by asserting reset before the first edge and by driving every input on the falling clock edge. The drop check applies only to the instance whose level count is not a power of two. A second instance of the bench, built with five as the top level, exercises that rule through its own bus.

// File: rtl/intc_prio_pkg.sv
package intc_prio_pkg;

  localparam int BUS_DW = 32;

  // True when the number of levels (max + 1) is a power of two.
  function automatic bit levels_pow2(input int unsigned max_p);
    return ((max_p + 1) & max_p) == 0;
  endfunction

  // Bits needed to hold 0..max_p, never less than one.
  function automatic int unsigned prio_width(input int unsigned max_p);
    return (max_p < 2) ? 1 : $clog2(max_p + 1);
  endfunction

  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/intc_addr_dec.sv
module intc_addr_dec #(
  parameter int ADDR_W     = 16,
  parameter int NUM_SRC    = 8,
  parameter int NUM_CTX    = 2,
  parameter int PRIO_BASE  = 'h0000,
  parameter int CTX_BASE   = 'h1000,
  parameter int CTX_STRIDE = 'h0100,
  localparam int SIW = intc_prio_pkg::idx_width(NUM_SRC),
  localparam int CIW = intc_prio_pkg::idx_width(NUM_CTX)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              prio_hit,
  output logic [SIW-1:0]    prio_idx,
  output logic              ctx_hit,
  output logic [CIW-1:0]    ctx_idx
);

  localparam logic [ADDR_W-1:0] P_BASE   = ADDR_W'(PRIO_BASE);
  localparam logic [ADDR_W-1:0] P_SPAN   = ADDR_W'(NUM_SRC * 4);
  localparam logic [ADDR_W-1:0] C_BASE   = ADDR_W'(CTX_BASE);
  localparam logic [ADDR_W-1:0] C_SPAN   = ADDR_W'(NUM_CTX * CTX_STRIDE);
  localparam logic [ADDR_W-1:0] C_MASK   = ADDR_W'(CTX_STRIDE - 1);
  localparam int                C_SHIFT  = $clog2(CTX_STRIDE);

  logic [ADDR_W-1:0] p_off;
  logic [ADDR_W-1:0] c_off;

  always_comb begin
    p_off    = addr - P_BASE;
    c_off    = addr - C_BASE;
    prio_hit = (addr >= P_BASE) && (p_off < P_SPAN) && (p_off[1:0] == 2'b00);
    prio_idx = SIW'(p_off >> 2);
    ctx_hit  = (addr >= C_BASE) && (c_off < C_SPAN) && ((c_off & C_MASK) == '0);
    ctx_idx  = CIW'(c_off >> C_SHIFT);
  end

endmodule

// File: rtl/intc_wr_legal.sv
module intc_wr_legal #(
  parameter int MAX_PRIO = 7,
  localparam int PW = intc_prio_pkg::prio_width(MAX_PRIO),
  localparam int DW = intc_prio_pkg::BUS_DW
) (
  input  logic [DW-1:0] wdata,
  output logic          accept,
  output logic [PW-1:0] value
);

  localparam bit POW2 = intc_prio_pkg::levels_pow2(MAX_PRIO);

  generate
    if (POW2) begin : g_mask
      // Write-any-read-legal: unsupported high bits are discarded.
      assign accept = 1'b1;
      assign value  = wdata[PW-1:0];
    end else begin : g_range
      // Out-of-range words are refused whole.
      assign accept = (wdata <= DW'(MAX_PRIO));
      assign value  = wdata[PW-1:0];
    end
  endgenerate

endmodule

// File: rtl/intc_ctx_eval.sv
module intc_ctx_eval #(
  parameter int NUM_SRC  = 8,
  parameter int MAX_PRIO = 7,
  localparam int PW = intc_prio_pkg::prio_width(MAX_PRIO)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC*PW-1:0] prio_flat,
  input  logic [PW-1:0]         thresh,
  input  logic [NUM_SRC-1:0]    pending,
  input  logic [NUM_SRC-1:0]    enable,
  output logic                  irq
);

  logic [NUM_SRC-1:0] above;

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      above[s] = pending[s] && enable[s] && (prio_flat[s*PW +: PW] > thresh);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |above;
  end

endmodule

// File: rtl/intc_prio_regs.sv
module intc_prio_regs #(
  parameter int NUM_SRC    = 8,
  parameter int MAX_PRIO   = 7,
  parameter int NUM_CTX    = 2,
  parameter int ADDR_W     = 16,
  parameter int PRIO_BASE  = 'h0000,
  parameter int CTX_BASE   = 'h1000,
  parameter int CTX_STRIDE = 'h0100
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_valid,
  input  logic                       bus_write,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [NUM_SRC-1:0]         src_pending,
  input  logic [NUM_CTX*NUM_SRC-1:0] ctx_enable,
  output logic [NUM_CTX-1:0]         ctx_irq
);

  localparam int PW  = intc_prio_pkg::prio_width(MAX_PRIO);
  localparam int SIW = intc_prio_pkg::idx_width(NUM_SRC);
  localparam int CIW = intc_prio_pkg::idx_width(NUM_CTX);
  localparam int DW  = intc_prio_pkg::BUS_DW;

  logic           prio_hit, ctx_hit;
  logic [SIW-1:0] prio_idx;
  logic [CIW-1:0] ctx_idx;
  logic           wr_ok;
  logic [PW-1:0]  wr_val;
  logic           wr_req, rd_req;
  logic [DW-1:0]  rd_val;

  logic [PW-1:0]          prio_q [NUM_SRC];
  logic [PW-1:0]          thr_q  [NUM_CTX];
  logic [NUM_SRC*PW-1:0]  prio_flat;
  logic [NUM_CTX*PW-1:0]  thr_flat;

  intc_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX),
    .PRIO_BASE(PRIO_BASE), .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
  ) u_dec (
    .addr(bus_addr), .prio_hit(prio_hit), .prio_idx(prio_idx),
    .ctx_hit(ctx_hit), .ctx_idx(ctx_idx)
  );

  intc_wr_legal #(.MAX_PRIO(MAX_PRIO)) u_legal (
    .wdata(bus_wdata), .accept(wr_ok), .value(wr_val)
  );

  assign wr_req = bus_valid && bus_write && wr_ok;
  assign rd_req = bus_valid && !bus_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SRC; s++) prio_q[s] <= '0;
    end else if (wr_req && prio_hit) begin
      prio_q[prio_idx] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CTX; c++) thr_q[c] <= '0;
    end else if (wr_req && ctx_hit) begin
      thr_q[ctx_idx] <= wr_val;
    end
  end

  always_comb begin
    rd_val = '0;
    if (prio_hit)     rd_val = DW'(prio_q[prio_idx]);
    else if (ctx_hit) rd_val = DW'(thr_q[ctx_idx]);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_pflat
      assign prio_flat[s*PW +: PW] = prio_q[s];
    end
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      assign thr_flat[c*PW +: PW] = thr_q[c];
      intc_ctx_eval #(.NUM_SRC(NUM_SRC), .MAX_PRIO(MAX_PRIO)) u_eval (
        .clk(clk), .rst(rst), .prio_flat(prio_flat), .thresh(thr_q[c]),
        .pending(src_pending), .enable(ctx_enable[c*NUM_SRC +: NUM_SRC]),
        .irq(ctx_irq[c])
      );
    end
  endgenerate

endmodule

// File: rtl/intc_prio_regs_chk.sv
module intc_prio_regs_chk #(
  parameter int NUM_SRC  = 8,
  parameter int MAX_PRIO = 7,
  parameter int NUM_CTX  = 2,
  parameter int ADDR_W   = 16,
  localparam int PW = intc_prio_pkg::prio_width(MAX_PRIO)
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_valid,
  input logic                       bus_write,
  input logic [31:0]                bus_wdata,
  input logic [31:0]                bus_rdata,
  input logic [NUM_SRC-1:0]         src_pending,
  input logic [NUM_CTX*NUM_SRC-1:0] ctx_enable,
  input logic [NUM_CTX-1:0]         ctx_irq,
  input logic [NUM_SRC*PW-1:0]      prio_flat,
  input logic [NUM_CTX*PW-1:0]      thr_flat
);

  localparam bit POW2 = intc_prio_pkg::levels_pow2(MAX_PRIO);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctx_irq == '0 && bus_rdata == '0)); // R9

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> (bus_rdata == '0)); // R10

  AST_RDATA_LEGAL: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> (bus_rdata <= 32'(MAX_PRIO))); // R3

  AST_DROP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!POW2 && bus_valid && bus_write && bus_wdata > 32'(MAX_PRIO))
      |=> ($stable(prio_flat) && $stable(thr_flat))); // R4

  AST_NEED_PENDING: assert property (@(posedge clk) disable iff (rst)
    (src_pending == '0) |=> (ctx_irq == '0)); // R6

  AST_NEED_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (ctx_enable == '0) |=> (ctx_irq == '0)); // R6

endmodule

bind intc_prio_regs intc_prio_regs_chk #(
  .NUM_SRC(NUM_SRC), .MAX_PRIO(MAX_PRIO), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_pending(src_pending),
  .ctx_enable(ctx_enable), .ctx_irq(ctx_irq), .prio_flat(prio_flat),
  .thr_flat(thr_flat)
);

// File: tb/test_intc_prio_regs.sv
module test_intc_prio_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic va = 1'b0, vb = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic [NS-1:0] pend = '0;
  logic [NC*NS-1:0] en = '0;
  logic [NC-1:0] irq_a, irq_b;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Instance with 8 levels (power of two)
  intc_prio_regs #(.NUM_SRC(NS), .MAX_PRIO(7), .NUM_CTX(NC)) i_intc_prio_regs (
    .clk(clk), .rst(rst), .bus_valid(va), .bus_write(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd_a), .src_pending(pend),
    .ctx_enable(en), .ctx_irq(irq_a)
  );

  // Instance with 6 levels (not a power of two)
  intc_prio_regs #(.NUM_SRC(NS), .MAX_PRIO(5), .NUM_CTX(NC)) i_intc_prio_regs_np (
    .clk(clk), .rst(rst), .bus_valid(vb), .bus_write(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd_b), .src_pending('0),
    .ctx_enable('0), .ctx_irq(irq_b)
  );

  function automatic logic [15:0] a_src(input int s);
    return 16'(4 * (s - 1));
  endfunction

  function automatic logic [15:0] a_thr(input int c);
    return 16'('h1000 + c * 'h100);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic bus_wr(input bit sel_b, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    if (sel_b) vb = 1'b1; else va = 1'b1;
    @(negedge clk);
    va = 1'b0; vb = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input bit sel_b, input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr = 1'b0;
    if (sel_b) vb = 1'b1; else va = 1'b1;
    @(negedge clk);
    d = sel_b ? rd_b : rd_a;
    va = 1'b0; vb = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R9 irq after reset", 32'(irq_a), 0);
    check("R9 rdata after reset", rd_a, 0);
    bus_rd(0, a_src(1), d);  check("R9 src1 reset", d, 0);
    bus_rd(0, a_thr(1), d);  check("R9 thr1 reset", d, 0);
  endtask

  task automatic t_prio_rw();
    logic [31:0] d;
    bus_wr(0, a_src(1), 5);     bus_rd(0, a_src(1), d); check("R1 src1", d, 5);
    bus_wr(0, a_src(8), 6);     bus_rd(0, a_src(8), d); check("R1 src8 last", d, 6);
    bus_wr(0, a_src(3), 'h1D);  bus_rd(0, a_src(3), d); check("R3 mod store", d, 5);
    bus_wr(0, a_src(4), 'hFFFF_FFF8); bus_rd(0, a_src(4), d); check("R3 high bits", d, 0);
  endtask

  task automatic t_thr_rw();
    logic [31:0] d;
    bus_wr(0, a_thr(1), 'hA);  bus_rd(0, a_thr(1), d); check("R5 thr1 masked", d, 2);
    bus_wr(0, a_thr(0), 3);    bus_rd(0, a_thr(0), d); check("R2 thr0", d, 3);
    bus_rd(0, a_thr(1), d);    check("R2 thr1 separate", d, 2);
  endtask

  task automatic t_irq();
    // src3 priority 5, thr1 = 2
    pend = 8'b0000_0100;
    en   = 16'h0004;
    bus_wr(0, a_thr(0), 0);
    @(negedge clk); check("R6 ctx0 only", 32'(irq_a), 1);
    bus_wr(0, a_thr(0), 5);
    @(negedge clk); check("R6 equal thr blocks", 32'(irq_a), 0);
    bus_wr(0, a_thr(0), 4);
    @(negedge clk); check("R6 prio above thr", 32'(irq_a), 1);
    en = 16'h0404;
    @(negedge clk); check("R6 ctx1 enabled", 32'(irq_a), 3);
    pend = '0;
    @(negedge clk); check("R6 not pending", 32'(irq_a), 0);
    en = '0;
  endtask

  task automatic t_prio_zero();
    bus_wr(0, a_src(2), 0);
    bus_wr(0, a_thr(0), 0);
    pend = 8'b0000_0010;
    en   = 16'h0202;
    @(negedge clk); @(negedge clk);
    check("R7 prio zero silent", 32'(irq_a), 0);
    bus_wr(0, a_src(2), 1);
    @(negedge clk); check("R7 prio one vs thr 0/2", 32'(irq_a), 1);
    pend = '0; en = '0;
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_wr(0, 16'h0020, 3);  bus_rd(0, 16'h0020, d); check("R8 past last src", d, 0);
    bus_wr(0, 16'h0001, 2);  bus_rd(0, a_src(1), d); check("R8 misaligned write", d, 5);
    bus_rd(0, 16'h0001, d);  check("R8 misaligned read", d, 0);
    bus_wr(0, 16'h1004, 7);  bus_rd(0, 16'h1004, d); check("R8 ctx hole", d, 0);
    bus_rd(0, a_thr(0), d);  check("R8 thr0 untouched", d, 0);
    bus_rd(0, 16'h1200, d);  check("R8 past last ctx", d, 0);
  endtask

  task automatic t_idle();
    logic [31:0] d;
    bus_rd(0, a_src(1), d);  check("R10 read value", d, 5);
    @(negedge clk);          check("R10 idle rdata", rd_a, 0);
    bus_wr(0, a_src(1), 5);  check("R10 rdata after write", rd_a, 0);
  endtask

  task automatic t_nonpow2();
    logic [31:0] d;
    bus_wr(1, a_src(1), 4);       bus_rd(1, a_src(1), d); check("R4 in range", d, 4);
    bus_wr(1, a_src(1), 6);       bus_rd(1, a_src(1), d); check("R4 6 dropped", d, 4);
    bus_wr(1, a_src(1), 'h100);   bus_rd(1, a_src(1), d); check("R4 wide dropped", d, 4);
    bus_wr(1, a_src(1), 5);       bus_rd(1, a_src(1), d); check("R4 max accepted", d, 5);
    bus_wr(1, a_thr(1), 5);       bus_rd(1, a_thr(1), d); check("R5 thr max", d, 5);
    bus_wr(1, a_thr(1), 7);       bus_rd(1, a_thr(1), d); check("R5 thr dropped", d, 5);
    bus_rd(0, a_thr(1), d);       check("R5 other instance untouched", d, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_prio_rw();
    t_thr_rw();
    t_irq();
    t_prio_zero();
    t_unmapped();
    t_idle();
    t_nonpow2();
    repeat (2) @(negedge clk);
    finish_sim();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

endmodule